// File: doc/BRIEF.md
# Floating-Point Exception Status and Reporting Unit

This block holds the floating-point status word and control word of a processor core. Arithmetic datapaths pulse exception strobes into it, including a divide-by-zero indication. The block keeps those flags sticky and works out the summary-error and busy bits from the flags that are pending and not masked. Clear-exceptions and initialise commands reset parts or all of the status word. A control-word write port changes the exception masks.

When the core executes a wait instruction, the block decides how to report. If the task-switched and monitor-coprocessor controls are both set, it raises a device-not-available trap. Otherwise, a pending summary error is reported in one of two ways, chosen by the numeric-error control. One is a native math-fault trap. The other is a legacy external error output that stays asserted until the error is cleared.

Top module: `fpu_fault_reporter`

## Requirements
- R1: After reset the status word is 0x0000, the control word is 0x003F, trap_valid_o and ferr_o are 0, and trap_vec_o is 0.
- R2: Each bit of exc_set_i sets the status bit at the same position (bit 0 invalid, 1 denormal, 2 zero-divide, 3 overflow, 4 underflow, 5 precision). stack_fault_i sets bit 6. All of these flags stay set until a clear or initialise command.
- R3: A pulse on div_valid_i while div_zero_i is 1 sets status bit 2. When div_zero_i is 0, the pulse leaves the status word unchanged.
- R4: Status bit 7 (summary error) and bit 15 (busy) are both set on the edge where any of status bits 0 to 5 is set while the control bit at the same position is 0. Flags that are all masked, and the stack-fault flag, set neither bit.
- R5: A control-word write is visible on control_o after the edge. If the write unmasks a pending flag, bits 7 and 15 are set on that same edge. A write that masks every pending flag leaves bits 7 and 15 set.
- R6: clr_exc_i ANDs the status word with 0x7F00.
- R7: init_i sets the status word to 0x0000. It takes priority over clr_exc_i.
- R8: When clr_exc_i and exception strobes arrive in the same cycle, the strobed flags are set in the result, and bits 7 and 15 are recomputed for them.
- R9: A wait request with cr0_mp_i and cr0_ts_i both 1 gives, on the next cycle, a one-cycle trap_valid_o with trap_vec_o = 7. No error reporting happens for that request, so ferr_o does not rise.
- R10: A wait request without both MP and TS set, while summary error is set and cr0_ne_i is 1, gives a one-cycle trap_valid_o with trap_vec_o = 16 on the next cycle.
- R11: The same request with cr0_ne_i at 0 raises ferr_o on the next cycle and produces no trap. ferr_o falls on the edge where a clear or initialise command clears summary error.
- R12: A wait request while summary error is clear produces no trap and leaves ferr_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_set_i | input | 6 | Exception flag set strobes, status bits 0 to 5 |
| stack_fault_i | input | 1 | Stack fault set strobe |
| div_valid_i | input | 1 | A divide (normal or reversed) completes |
| div_zero_i | input | 1 | Divisor of that divide was zero |
| clr_exc_i | input | 1 | Clear-exceptions command |
| init_i | input | 1 | Initialise command |
| cw_we_i | input | 1 | Control word write enable |
| cw_wdata_i | input | 16 | Control word write data |
| cr0_mp_i | input | 1 | Monitor-coprocessor control |
| cr0_ts_i | input | 1 | Task-switched control |
| cr0_ne_i | input | 1 | Numeric-error reporting select |
| wait_req_i | input | 1 | Wait instruction request |
| status_o | output | 16 | Status word |
| control_o | output | 16 | Control word |
| trap_valid_o | output | 1 | One-cycle trap pulse |
| trap_vec_o | output | 8 | Trap vector number, 0 when idle |
| ferr_o | output | 1 | Legacy external error output |

## Verification
The hardest case to reach is the release of ferr_o. Getting there needs an unmasked pending flag, a wait with NE clear and MP/TS not both set, and then a clear command. Stimulus first unmasks an already pending zero-divide flag through a control write, so that summary error is set without a new strobe. A later task issues the legacy-reporting wait, holds idle cycles to show that ferr_o stays high, and then clears. A separate task puts a clear and a strobe in the same cycle to show that the set wins.

// File: rtl/fpu_fault_pkg.sv
package fpu_fault_pkg;
  localparam int SW_W    = 16;
  localparam int EXC_N   = 6;
  localparam int IDX_ZE  = 2;
  localparam int IDX_SF  = 6;
  localparam int IDX_SE  = 7;
  localparam int IDX_B   = 15;
  localparam logic [SW_W-1:0] KEEP_MASK = 16'h7F00;

  typedef enum logic [1:0] {
    WD_NONE = 2'd0,
    WD_NM   = 2'd1,
    WD_MF   = 2'd2,
    WD_FERR = 2'd3
  } wait_dec_e;
endpackage

// File: rtl/fpu_ctrl_reg.sv
module fpu_ctrl_reg #(
  parameter int CW_W = 16,
  parameter logic [CW_W-1:0] CW_RESET = 16'h003F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_i,
  input  logic [CW_W-1:0] wdata_i,
  output logic [CW_W-1:0] cw_d_o,
  output logic [CW_W-1:0] cw_q_o
);
  logic [CW_W-1:0] cw_q;

  always_comb begin
    cw_d_o = we_i ? wdata_i : cw_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cw_q <= CW_RESET;
    else if (we_i) cw_q <= wdata_i;
  end

  assign cw_q_o = cw_q;
endmodule

// File: rtl/fpu_status_reg.sv
module fpu_status_reg
  import fpu_fault_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EXC_N-1:0] exc_set_i,
  input  logic             sf_i,
  input  logic             div_valid_i,
  input  logic             div_zero_i,
  input  logic             clr_i,
  input  logic             init_i,
  input  logic             mask_chg_i,
  input  logic [EXC_N-1:0] mask_i,
  output logic [SW_W-1:0]  status_o,
  output logic             se_next_o
);
  logic [SW_W-1:0] status_q, status_d, base, add;
  logic            upd;

  always_comb begin
    base = status_q;
    if (init_i)     base = '0;
    else if (clr_i) base = status_q & KEEP_MASK;

    add = '0;
    add[EXC_N-1:0] = exc_set_i;
    add[IDX_ZE]    = add[IDX_ZE] | (div_valid_i & div_zero_i);
    add[IDX_SF]    = sf_i;

    status_d = base | add;
    if (|(status_d[EXC_N-1:0] & ~mask_i)) begin
      status_d[IDX_SE] = 1'b1;
      status_d[IDX_B]  = 1'b1;
    end
    upd = init_i | clr_i | mask_chg_i | (|add);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   status_q <= '0;
    else if (upd) status_q <= status_d;
  end

  assign status_o  = status_q;
  assign se_next_o = upd ? status_d[IDX_SE] : status_q[IDX_SE];
endmodule

// File: rtl/fpu_wait_unit.sv
module fpu_wait_unit
  import fpu_fault_pkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int VEC_NM = 7,
  parameter int VEC_MF = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wait_i,
  input  logic             mp_i,
  input  logic             ts_i,
  input  logic             ne_i,
  input  logic             se_q_i,
  input  logic             se_next_i,
  output logic             trap_valid_o,
  output logic [VEC_W-1:0] trap_vec_o,
  output logic             ferr_o
);
  wait_dec_e        dec;
  logic             tv_d, tv_q, ferr_d, ferr_q;
  logic [VEC_W-1:0] vec_d, vec_q;

  always_comb begin
    dec = WD_NONE;
    if (wait_i) begin
      if (mp_i && ts_i) dec = WD_NM;
      else if (se_q_i)  dec = ne_i ? WD_MF : WD_FERR;
    end
    tv_d = (dec == WD_NM) || (dec == WD_MF);
    case (dec)
      WD_NM:   vec_d = VEC_W'(VEC_NM);
      WD_MF:   vec_d = VEC_W'(VEC_MF);
      default: vec_d = '0;
    endcase
    ferr_d = (dec == WD_FERR) | (ferr_q & se_next_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tv_q   <= 1'b0;
      vec_q  <= '0;
      ferr_q <= 1'b0;
    end else begin
      tv_q   <= tv_d;
      vec_q  <= vec_d;
      ferr_q <= ferr_d;
    end
  end

  assign trap_valid_o = tv_q;
  assign trap_vec_o   = vec_q;
  assign ferr_o       = ferr_q;
endmodule

// File: rtl/fpu_fault_reporter.sv
module fpu_fault_reporter
  import fpu_fault_pkg::*;
#(
  parameter int CW_W  = 16,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [5:0]       exc_set_i,
  input  logic             stack_fault_i,
  input  logic             div_valid_i,
  input  logic             div_zero_i,
  input  logic             clr_exc_i,
  input  logic             init_i,
  input  logic             cw_we_i,
  input  logic [15:0]      cw_wdata_i,
  input  logic             cr0_mp_i,
  input  logic             cr0_ts_i,
  input  logic             cr0_ne_i,
  input  logic             wait_req_i,
  output logic [15:0]      status_o,
  output logic [15:0]      control_o,
  output logic             trap_valid_o,
  output logic [7:0]       trap_vec_o,
  output logic             ferr_o
);
  logic [1:0]      rst_sync;
  logic            rst_int_n;
  logic [CW_W-1:0] cw_d, cw_q;
  logic [SW_W-1:0] status;
  logic            se_next;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  fpu_ctrl_reg #(.CW_W(CW_W), .CW_RESET(CW_W'(16'h003F))) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .we_i    (cw_we_i),
    .wdata_i (CW_W'(cw_wdata_i)),
    .cw_d_o  (cw_d),
    .cw_q_o  (cw_q)
  );

  fpu_status_reg u_status (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .exc_set_i   (exc_set_i),
    .sf_i        (stack_fault_i),
    .div_valid_i (div_valid_i),
    .div_zero_i  (div_zero_i),
    .clr_i       (clr_exc_i),
    .init_i      (init_i),
    .mask_chg_i  (cw_we_i),
    .mask_i      (cw_d[EXC_N-1:0]),
    .status_o    (status),
    .se_next_o   (se_next)
  );

  fpu_wait_unit #(.VEC_W(VEC_W), .VEC_NM(7), .VEC_MF(16)) u_wait (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .wait_i       (wait_req_i),
    .mp_i         (cr0_mp_i),
    .ts_i         (cr0_ts_i),
    .ne_i         (cr0_ne_i),
    .se_q_i       (status[IDX_SE]),
    .se_next_i    (se_next),
    .trap_valid_o (trap_valid_o),
    .trap_vec_o   (trap_vec_o),
    .ferr_o       (ferr_o)
  );

  assign status_o  = status;
  assign control_o = 16'(cw_q);
endmodule

// File: rtl/fpu_fault_reporter_chk.sv
module fpu_fault_reporter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [5:0]  exc_set_i,
  input logic        stack_fault_i,
  input logic        div_valid_i,
  input logic        div_zero_i,
  input logic        clr_exc_i,
  input logic        init_i,
  input logic        cr0_mp_i,
  input logic        cr0_ts_i,
  input logic        cr0_ne_i,
  input logic        wait_req_i,
  input logic [15:0] status_o,
  input logic        trap_valid_o,
  input logic [7:0]  trap_vec_o,
  input logic        ferr_o
);
  logic quiet;
  assign quiet = (exc_set_i == 6'd0) && !stack_fault_i && !(div_valid_i && div_zero_i);

  assert_se_busy_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[7] == status_o[15]);

  assert_clear_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_exc_i && quiet) |=> (status_o[7:0] == 8'h00 && !status_o[15]));

  assert_init_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (init_i && quiet) |=> (status_o == 16'h0000));

  assert_strobe_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && exc_set_i != 6'd0) |=> ((status_o[5:0] & $past(exc_set_i)) == $past(exc_set_i)));

  assert_nm_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_req_i && cr0_mp_i && cr0_ts_i) |=> (trap_valid_o && trap_vec_o == 8'd7));

  assert_vec_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid_o |-> (trap_vec_o == 8'd7 || trap_vec_o == 8'd16));

  assert_ferr_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ferr_o) |-> $past(wait_req_i && !cr0_ne_i && !(cr0_mp_i && cr0_ts_i)));

  assert_no_wait_no_trap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_req_i |=> !trap_valid_o);
endmodule

bind fpu_fault_reporter fpu_fault_reporter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .exc_set_i(exc_set_i), .stack_fault_i(stack_fault_i),
  .div_valid_i(div_valid_i), .div_zero_i(div_zero_i), .clr_exc_i(clr_exc_i),
  .init_i(init_i), .cr0_mp_i(cr0_mp_i), .cr0_ts_i(cr0_ts_i), .cr0_ne_i(cr0_ne_i),
  .wait_req_i(wait_req_i), .status_o(status_o), .trap_valid_o(trap_valid_o),
  .trap_vec_o(trap_vec_o), .ferr_o(ferr_o)
);

// File: tb/fpu_fault_reporter_test.sv
module fpu_fault_reporter_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk, rst_n;
  logic [5:0]  exc_set_i;
  logic        stack_fault_i, div_valid_i, div_zero_i, clr_exc_i, init_i;
  logic        cw_we_i;
  logic [15:0] cw_wdata_i;
  logic        cr0_mp_i, cr0_ts_i, cr0_ne_i, wait_req_i;
  logic [15:0] status_o, control_o;
  logic        trap_valid_o, ferr_o;
  logic [7:0]  trap_vec_o;

  int checks = 0;
  int fails  = 0;

  fpu_fault_reporter uut (
    .clk(clk), .rst_n(rst_n), .exc_set_i(exc_set_i), .stack_fault_i(stack_fault_i),
    .div_valid_i(div_valid_i), .div_zero_i(div_zero_i), .clr_exc_i(clr_exc_i),
    .init_i(init_i), .cw_we_i(cw_we_i), .cw_wdata_i(cw_wdata_i),
    .cr0_mp_i(cr0_mp_i), .cr0_ts_i(cr0_ts_i), .cr0_ne_i(cr0_ne_i),
    .wait_req_i(wait_req_i), .status_o(status_o), .control_o(control_o),
    .trap_valid_o(trap_valid_o), .trap_vec_o(trap_vec_o), .ferr_o(ferr_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic quiet_inputs();
    exc_set_i = '0; stack_fault_i = 0; div_valid_i = 0; div_zero_i = 0;
    clr_exc_i = 0; init_i = 0; cw_we_i = 0; cw_wdata_i = '0; wait_req_i = 0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic test_reset();
    check("R1 status", status_o, 16'h0000);
    check("R1 control", control_o, 16'h003F);
    check("R1 trap", {15'd0, trap_valid_o}, 16'd0);
    check("R1 vec", {8'd0, trap_vec_o}, 16'd0);
    check("R1 ferr", {15'd0, ferr_o}, 16'd0);
  endtask

  task automatic test_masked_flags();
    exc_set_i = 6'b000101; tick(); quiet_inputs();
    check("R2/R4 masked flags", status_o, 16'h0005);
    stack_fault_i = 1; tick(); quiet_inputs();
    check("R2/R4 stack fault", status_o, 16'h0045);
    tick(); tick();
    check("R2 sticky", status_o, 16'h0045);
    clr_exc_i = 1; tick(); quiet_inputs();
    check("R6 clear", status_o, 16'h0000);
  endtask

  task automatic test_divide();
    div_valid_i = 1; div_zero_i = 0; tick(); quiet_inputs();
    check("R3 nonzero divisor", status_o, 16'h0000);
    div_valid_i = 1; div_zero_i = 1; tick(); quiet_inputs();
    check("R3 zero divisor", status_o, 16'h0004);
  endtask

  task automatic test_unmask();
    cw_we_i = 1; cw_wdata_i = 16'h003B; tick(); quiet_inputs();
    check("R5 control", control_o, 16'h003B);
    check("R5 unmask pending", status_o, 16'h8084);
    cw_we_i = 1; cw_wdata_i = 16'h003F; tick(); quiet_inputs();
    check("R5 remask keeps", status_o, 16'h8084);
  endtask

  task automatic test_native_trap();
    cr0_mp_i = 0; cr0_ts_i = 1; cr0_ne_i = 1; wait_req_i = 1; tick(); quiet_inputs();
    check("R10 trap", {15'd0, trap_valid_o}, 16'd1);
    check("R10 vec", {8'd0, trap_vec_o}, 16'd16);
    tick();
    check("R10 pulse", {15'd0, trap_valid_o}, 16'd0);
  endtask

  task automatic test_nm_trap();
    cr0_mp_i = 1; cr0_ts_i = 1; cr0_ne_i = 0; wait_req_i = 1; tick(); quiet_inputs();
    check("R9 trap", {15'd0, trap_valid_o}, 16'd1);
    check("R9 vec", {8'd0, trap_vec_o}, 16'd7);
    check("R9 no ferr", {15'd0, ferr_o}, 16'd0);
    tick();
    check("R9 pulse", {15'd0, trap_valid_o}, 16'd0);
  endtask

  task automatic test_ferr();
    cr0_mp_i = 1; cr0_ts_i = 0; cr0_ne_i = 0; wait_req_i = 1; tick(); quiet_inputs();
    check("R11 ferr up", {15'd0, ferr_o}, 16'd1);
    check("R11 no trap", {15'd0, trap_valid_o}, 16'd0);
    tick(); tick();
    check("R11 ferr held", {15'd0, ferr_o}, 16'd1);
    clr_exc_i = 1; tick(); quiet_inputs();
    check("R6 clear all", status_o, 16'h0000);
    check("R11 ferr released", {15'd0, ferr_o}, 16'd0);
  endtask

  task automatic test_no_error_wait();
    cr0_mp_i = 0; cr0_ts_i = 0; cr0_ne_i = 1; wait_req_i = 1; tick(); quiet_inputs();
    check("R12 no trap", {15'd0, trap_valid_o}, 16'd0);
    cr0_ne_i = 0; wait_req_i = 1; tick(); quiet_inputs();
    check("R12 no ferr", {15'd0, ferr_o}, 16'd0);
  endtask

  task automatic test_clear_vs_set();
    cw_we_i = 1; cw_wdata_i = 16'h003E; tick(); quiet_inputs();
    check("R5 no pending", status_o, 16'h0000);
    exc_set_i = 6'b001000; tick(); quiet_inputs();
    check("R4 masked overflow", status_o, 16'h0008);
    clr_exc_i = 1; exc_set_i = 6'b000001; tick(); quiet_inputs();
    check("R8 set wins", status_o, 16'h8081);
  endtask

  task automatic test_init();
    init_i = 1; clr_exc_i = 1; tick(); quiet_inputs();
    check("R7 init", status_o, 16'h0000);
  endtask

  initial begin
    quiet_inputs();
    cr0_mp_i = 0; cr0_ts_i = 0; cr0_ne_i = 0;
    rst_n = 0;
    repeat (3) tick();
    rst_n = 1;
    repeat (3) tick();
    test_reset();
    test_masked_flags();
    test_divide();
    test_unmask();
    test_native_trap();
    test_nm_trap();
    test_ferr();
    test_no_error_wait();
    test_clear_vs_set();
    test_init();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired, all requirements: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule